// File: doc/BRIEF.md
# Stalled-Rotor Fault Timer

This block protects a brushless motor drive against a stalled rotor. It watches the speed-lock flag from the speed control loop and counts slow timebase ticks while that flag reports out-of-lock. When the out-of-lock condition has lasted continuously for a programmed number of ticks, the block raises a fault. The fault blanks all three high-side drive requests before they reach the power stage.

The fault is sticky. The lock flag returning to in-lock does not remove it. Only a stop command or a reset clears it. A strap input turns the whole protection off, and it also clears the timer and any fault that is present.

The slow timebase is an external oscillator, modelled here as a one-cycle tick input. The hold setting is a tick count, so a hold window of a few seconds depends on the tick rate chosen by the integrator.

Top module: `stall_guard`

## Requirements
- R1: While `rst` is high, at the next clock edge `fault_o` goes to 0, `hs_o` goes to 3'b000 and the tick count goes to zero.
- R2: Let H be the value of `hold_ticks_i`, with H ≥ 1. `fault_o` goes to 1 on the clock edge after the H-th consecutive counted tick. After H−1 ticks, `fault_o` is still 0.
- R3: A cycle with `in_lock_i`=1 resets the tick count to zero, so a later stall needs a full H ticks again.
- R4: `hs_o` is registered. It carries `hs_req_i` (bit 0 = phase A, bit 1 = phase B, bit 2 = phase C), delayed by one cycle, while no fault is present. It is 3'b000 in every cycle where `fault_o` is 1.
- R5: Once `fault_o` is 1, it stays 1 while `stop_i`, `guard_off_i` and `rst` are all low, whatever `in_lock_i` and `tick_i` do.
- R6: `stop_i`=1 clears `fault_o` at the next clock edge. While `stop_i` is high, the tick count is held at zero, so ticks during a stop never lead to a fault.
- R7: `guard_off_i`=1 clears `fault_o` at the next clock edge and holds the tick count at zero. No fault can set while the strap is high.
- R8: A hold setting of 0 acts as 1: a single out-of-lock tick sets the fault.
- R9: Clock cycles with `tick_i`=0 do not advance the tick count.
- R10: The largest hold setting, 65535, trips after exactly 65535 ticks and not after 65534.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase tick |
| in_lock_i | input | 1 | 1 = speed within lock range, 0 = out of lock |
| stop_i | input | 1 | 1 = motor commanded to stop |
| guard_off_i | input | 1 | Strap; 1 = protection disabled |
| hold_ticks_i | input | 16 | Hold time in ticks (CNT_W bits) |
| hs_req_i | input | 3 | High-side drive requests from commutation |
| fault_o | output | 1 | Latched stall fault |
| hs_o | output | 3 | Gated high-side drive |

## Verification
The bench builds the block with the default 16-bit count width and drives a tick on chosen clock cycles. With that setup, the exact trip point can be checked both for small hold values such as 0, 2, 4 and 5 and for the full 65535 setting, with a tick on every cycle for the full-range case. Small holds make the cases short to run: a restart after a brief in-lock return, ticks arriving during stop and strap, and tickless idle gaps. The full-range run shows that the count comparison has no off-by-one error at the top of the 16-bit range.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;
  localparam int NUM_PHASES = 3;
  typedef logic [NUM_PHASES-1:0] phase_vec_t;
endpackage

// File: rtl/stall_tick_timer.sv
module stall_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             expire_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + EXT_W'(1);
  assign expire_o = tick_i && !clear_i && (cnt_inc >= {1'b0, hold_i});

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (tick_i && !(&cnt_q)) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  // R3
  cnt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));

  // R9
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/stall_fault_latch.sv
module stall_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic stop_i,
  input  logic guard_off_i,
  output logic fault_d_o,
  output logic fault_o
);
  logic fault_q;

  always_comb begin
    if (stop_i || guard_off_i) fault_d_o = 1'b0;
    else                       fault_d_o = fault_q || expire_i;
  end

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= fault_d_o;
  end

  assign fault_o = fault_q;

  // R2
  rise_needs_expire_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> $past(expire_i));

  // R5
  sticky_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !stop_i && !guard_off_i) |=> fault_q);

  // R6
  stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !fault_q);

  // R7
  strap_clears_chk: assert property (@(posedge clk) disable iff (rst)
    guard_off_i |=> !fault_q);
endmodule

// File: rtl/stall_hs_gate.sv
module stall_hs_gate
  import stall_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fault_d_i,
  input  phase_vec_t hs_req_i,
  output phase_vec_t hs_o
);
  phase_vec_t hs_q;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst) hs_q[p] <= 1'b0;
      else     hs_q[p] <= hs_req_i[p] && !fault_d_i;
    end
  end

  assign hs_o = hs_q;
endmodule

// File: rtl/stall_guard.sv
module stall_guard
  import stall_guard_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             in_lock_i,
  input  logic             stop_i,
  input  logic             guard_off_i,
  input  logic [CNT_W-1:0] hold_ticks_i,
  input  logic [2:0]       hs_req_i,
  output logic             fault_o,
  output logic [2:0]       hs_o
);
  logic       timer_clear;
  logic       expire;
  logic       fault_d;
  logic       fault_q;
  phase_vec_t hs_gated;

  assign timer_clear = in_lock_i || stop_i || guard_off_i;

  stall_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .clear_i  (timer_clear),
    .hold_i   (hold_ticks_i),
    .expire_o (expire)
  );

  stall_fault_latch u_latch (
    .clk         (clk),
    .rst         (rst),
    .expire_i    (expire),
    .stop_i      (stop_i),
    .guard_off_i (guard_off_i),
    .fault_d_o   (fault_d),
    .fault_o     (fault_q)
  );

  stall_hs_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .fault_d_i (fault_d),
    .hs_req_i  (hs_req_i),
    .hs_o      (hs_gated)
  );

  assign fault_o = fault_q;
  assign hs_o    = hs_gated;

  // R4
  hs_blank_chk: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> (hs_gated == '0));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!fault_q && hs_gated == '0));
endmodule

// File: tb/stall_guard_tb.sv
module stall_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        in_lock = 1'b1;
  logic        stop = 1'b0;
  logic        strap = 1'b0;
  logic [15:0] hold = 16'd5;
  logic [2:0]  hs_req = 3'b101;
  logic        fault;
  logic [2:0]  hs;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stall_guard u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .in_lock_i(in_lock),
    .stop_i(stop), .guard_off_i(strap), .hold_ticks_i(hold),
    .hs_req_i(hs_req), .fault_o(fault), .hs_o(hs)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_pulse();
    @(negedge clk); in_lock = 1'b1; stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic t_reset();
    idle(3);
    check(fault, 0, "R1 fault in reset");
    check(hs, 0, "R1 hs in reset");
    rst = 1'b0;
    idle(2);
    check(hs, 3'b101, "R4 hs follows request");
  endtask

  task automatic t_trip();
    hold = 16'd5; in_lock = 1'b0;
    ticks(4);
    check(fault, 0, "R2 no fault at H-1");
    idle(10);
    check(fault, 0, "R9 idle cycles do not count");
    ticks(1);
    check(fault, 1, "R2 fault at H");
    check(hs, 0, "R4 hs blanked");
    in_lock = 1'b1;
    idle(5);
    check(fault, 1, "R5 in-lock does not clear");
    check(hs, 0, "R4 hs still blanked");
    stop_pulse();
    check(fault, 0, "R6 stop clears fault");
    idle(1);
    check(hs, 3'b101, "R4 hs restored");
  endtask

  task automatic t_restart();
    hold = 16'd4; in_lock = 1'b0;
    ticks(3);
    @(negedge clk); in_lock = 1'b1;
    @(negedge clk); in_lock = 1'b0;
    ticks(3);
    check(fault, 0, "R3 count restarted");
    ticks(1);
    check(fault, 1, "R3 trip after full window");
    stop_pulse();
  endtask

  task automatic t_stop_hold();
    hold = 16'd2; in_lock = 1'b0;
    @(negedge clk); stop = 1'b1;
    ticks(10);
    check(fault, 0, "R6 no fault while stopped");
    @(negedge clk); stop = 1'b0;
    ticks(1);
    check(fault, 0, "R6 count held at zero in stop");
    ticks(1);
    check(fault, 1, "R2 trip after stop released");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(fault, 0, "R1 reset clears fault");
    in_lock = 1'b1;
  endtask

  task automatic t_strap();
    hold = 16'd2; in_lock = 1'b0;
    @(negedge clk); strap = 1'b1;
    ticks(5);
    check(fault, 0, "R7 strap blocks fault");
    @(negedge clk); strap = 1'b0;
    ticks(2);
    check(fault, 1, "R7 trip after strap released");
    @(negedge clk); strap = 1'b1;
    @(negedge clk); strap = 1'b0;
    check(fault, 0, "R7 strap clears fault");
    ticks(1);
    check(fault, 0, "R7 strap cleared count");
    stop_pulse();
  endtask

  task automatic t_hold_zero();
    hold = 16'd0; in_lock = 1'b0;
    ticks(1);
    check(fault, 1, "R8 hold zero trips on one tick");
    stop_pulse();
  endtask

  task automatic t_full();
    hold = 16'hFFFF; in_lock = 1'b0;
    ticks(65534);
    check(fault, 0, "R10 no trip at 65534");
    ticks(1);
    check(fault, 1, "R10 trip at 65535");
    stop_pulse();
  endtask

  initial begin
    t_reset();
    t_trip();
    t_restart();
    t_stop_hold();
    t_strap();
    t_hold_zero();
    t_full();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule